// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer

The block holds an eight-bit word whose bits are written one at a time. A three-bit address picks the bit, a single data line supplies its value, and an active-low enable allows the write. Two control lines, the active-low clear and the active-low enable, select one of four modes. The modes are: write the addressed bit, hold every bit, route the data line to the addressed output with all other outputs low, or clear the whole word. This lets the block serve as a serial-to-parallel holding register, as a bank of individually set control flags, or as a 1-of-8 decoder.

Storage is built from flip-flops that sample on the system clock. A write therefore lands at the clock edge. Clear forces the outputs low at once, without waiting for a clock edge, and empties the storage at the next edge. Demultiplexer outputs are combinational from the address and data inputs and do not disturb the stored word.

Top module: `addr_latch_demux`

## Requirements
- R1: When rst_ni is low, the stored word is zero, so q_o reads 8'h00 in hold mode once reset is released.
- R2: Write mode is clr_ni=1 and en_ni=0. At each rising clock edge in this mode, the bit selected by addr_i takes the value of data_i, and q_o shows the stored word.
- R3: A write never changes any bit other than the addressed one.
- R4: Hold mode is clr_ni=1 and en_ni=1. In this mode no bit changes, whatever addr_i and data_i do.
- R5: Demultiplexer mode is clr_ni=0 and en_ni=0. In this mode, in the same cycle, q_o[addr_i] equals data_i and every other bit of q_o is 0.
- R6: Demultiplexer mode leaves the stored word untouched. On return to hold mode, q_o shows the word stored before.
- R7: Clear mode is clr_ni=0 and en_ni=1. In this mode q_o is 8'h00 in the same cycle without waiting for a clock edge, and the stored word is zero from the next rising edge on.
- R8: addr_i is an unsigned binary number with bit 0 as its least significant bit. Value 0 selects q_o[0] and value 7 selects q_o[7].
- R9: While en_ni stays low on one address across several edges, the value of data_i sampled at the last edge is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; storage samples on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the storage |
| addr_i | input | 3 | Bit select, binary |
| data_i | input | 1 | Value to write or to route |
| en_ni | input | 1 | Active-low enable |
| clr_ni | input | 1 | Active-low clear; together with en_ni it selects the mode |
| q_o | output | 8 | Parallel output word |

## Verification
Two situations combine functions in one cycle. In the first, a write at one edge is followed at once by a clear or a demultiplexer cycle. The bench then judges both effects: the combinational output that the new mode dictates, and the stored word once hold mode resumes. In the second, the bench keeps enable low across back-to-back edges while the data toggles, and expects only the last sample to be kept. Random vectors switch mode on every cycle to provoke both situations. A bench model predicts the output after each edge, and that prediction is compared with q_o.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;

  function automatic mode_e decode_mode(input logic clr_n, input logic en_n);
    case ({clr_n, en_n})
      2'b10:   return MODE_WRITE;
      2'b11:   return MODE_HOLD;
      2'b00:   return MODE_DEMUX;
      default: return MODE_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import addr_latch_pkg::*;
(
  input  logic clr_ni,
  input  logic en_ni,
  output logic wr_o,
  output logic demux_o,
  output logic clear_o
);
  mode_e mode;

  always_comb begin
    mode    = decode_mode(clr_ni, en_ni);
    wr_o    = (mode == MODE_WRITE);
    demux_o = (mode == MODE_DEMUX);
    clear_o = (mode == MODE_CLEAR);
  end
endmodule

// File: rtl/al_addr_dec.sv
module al_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N-1:0]      sel_o
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/al_store_bank.sv
module al_store_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sel_i,
  input  logic         data_i,
  input  logic         wr_i,
  input  logic         clear_i,
  output logic [N-1:0] store_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                store_o[i] <= 1'b0;
      else if (clear_i)           store_o[i] <= 1'b0;
      else if (wr_i && sel_i[i])  store_o[i] <= data_i;
    end
  end
endmodule

// File: rtl/al_out_sel.sv
module al_out_sel #(
  parameter int N = 8
) (
  input  logic [N-1:0] store_i,
  input  logic [N-1:0] sel_i,
  input  logic         data_i,
  input  logic         demux_i,
  input  logic         clear_i,
  output logic [N-1:0] q_o
);
  // clear overrides storage at once, without a clock edge
  always_comb begin
    if (demux_i)      q_o = sel_i & {N{data_i}};
    else if (clear_i) q_o = '0;
    else              q_o = store_i;
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_i,
  input  logic              en_ni,
  input  logic              clr_ni,
  output logic [N-1:0]      q_o
);
  logic         wr, demux, clear;
  logic [N-1:0] sel, store;

  al_mode_dec u_mode (
    .clr_ni (clr_ni),
    .en_ni  (en_ni),
    .wr_o   (wr),
    .demux_o(demux),
    .clear_o(clear)
  );

  al_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  al_store_bank #(.N(N)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .data_i (data_i),
    .wr_i   (wr),
    .clear_i(clear),
    .store_o(store)
  );

  al_out_sel #(.N(N)) u_out (
    .store_i(store),
    .sel_i  (sel),
    .data_i (data_i),
    .demux_i(demux),
    .clear_i(clear),
    .q_o    (q_o)
  );
endmodule

// File: rtl/al_checker.sv
module al_checker #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              data_i,
  input logic              en_ni,
  input logic              clr_ni,
  input logic [N-1:0]      q_o
);
  logic wr_m, hold_m, dmx_m, clr_m;
  logic [N-1:0] bit_m;
  logic armed;

  assign wr_m   =  clr_ni && !en_ni;
  assign hold_m =  clr_ni &&  en_ni;
  assign dmx_m  = !clr_ni && !en_ni;
  assign clr_m  = !clr_ni &&  en_ni;
  assign bit_m  = {{(N-1){1'b0}}, 1'b1} << addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && hold_m && $past(hold_m)) |-> $stable(q_o)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_m |-> (q_o == '0)); // R7

  AST_CLEAR_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && hold_m && $past(clr_m)) |-> (q_o == '0)); // R7

  AST_DEMUX_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmx_m |-> (($countones(q_o) == 32'(data_i)) && ((q_o & bit_m) == (bit_m & {N{data_i}})))); // R5

  AST_WRITE_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(wr_m) && hold_m) |-> (((q_o ^ $past(q_o)) & ~$past(bit_m)) == '0)); // R3

  AST_WRITE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(wr_m) && hold_m) |-> ((q_o & $past(bit_m)) == ($past(bit_m) & {N{$past(data_i)}}))); // R2
endmodule

bind addr_latch_demux al_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .addr_i(addr_i),
  .data_i(data_i),
  .en_ni (en_ni),
  .clr_ni(clr_ni),
  .q_o   (q_o)
);

// File: tb/tb_addr_latch_demux.sv
module tb_addr_latch_demux;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          data_i = 1'b0;
  logic          en_ni = 1'b1;
  logic          clr_ni = 1'b1;
  logic [N-1:0]  q_o;

  int nvec = 0;
  int nerr = 0;
  logic [N-1:0] model = '0;

  always #2.5 clk_i = ~clk_i;

  addr_latch_demux #(.ADDR_W(AW)) dut (.*);

  function automatic logic [N-1:0] onehot(input logic [AW-1:0] a);
    return {{(N-1){1'b0}}, 1'b1} << a;
  endfunction

  function automatic logic [N-1:0] expect_q(input logic c, input logic e,
                                            input logic [AW-1:0] a, input logic d,
                                            input logic [N-1:0] st);
    if (!c && !e) return onehot(a) & {N{d}};
    if (!c &&  e) return '0;
    return st;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, compare just after it
  task automatic step(input logic c, input logic e, input logic [AW-1:0] a,
                      input logic d, input string req);
    logic [N-1:0] prev;
    @(negedge clk_i);
    clr_ni = c; en_ni = e; addr_i = a; data_i = d;
    #1;
    if (!c && e) chk("R7 same-cycle clear", q_o, '0);
    if (!c && !e) chk("R5 same-cycle demux", q_o, onehot(a) & {N{d}});
    prev = model;
    if (c && !e) model[a] = d;
    else if (!c && e) model = '0;
    @(posedge clk_i);
    #1;
    chk(req, q_o, expect_q(c, e, a, d, model));
    if (c && !e) chk("R3 others unchanged", q_o & ~onehot(a), prev & ~onehot(a));
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset output", q_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 3'd5, 1'b1, "R1 hold after reset");

    // R8: write each address alone, check exact bit position
    for (int i = 0; i < N; i++) begin
      step(1'b1, 1'b0, AW'(i), 1'b1, "R2 R8 write bit");
      chk("R8 position", q_o, (onehot(AW'(i)) << 1) - 1'b1 | onehot(AW'(i)));
    end
    step(1'b1, 1'b1, 3'd0, 1'b0, "R4 hold full word");
    chk("R4 all ones held", q_o, {N{1'b1}});

    // R5/R6: demux every address both levels, storage unchanged
    for (int i = 0; i < N; i++) begin
      step(1'b0, 1'b0, AW'(i), 1'b1, "R5 demux high");
      step(1'b0, 1'b0, AW'(i), 1'b0, "R5 demux low");
    end
    step(1'b1, 1'b1, 3'd3, 1'b0, "R6 storage after demux");
    chk("R6 word kept", q_o, {N{1'b1}});

    // R9: enable held low, data toggles on one address
    step(1'b1, 1'b0, 3'd6, 1'b0, "R9 toggle 0");
    step(1'b1, 1'b0, 3'd6, 1'b1, "R9 toggle 1");
    step(1'b1, 1'b0, 3'd6, 1'b0, "R9 toggle 0 last");
    step(1'b1, 1'b1, 3'd6, 1'b1, "R9 last sample kept");
    chk("R9 bit6 low", q_o & onehot(3'd6), '0);

    // R7: clear then hold
    step(1'b0, 1'b1, 3'd2, 1'b1, "R7 clear");
    step(1'b1, 1'b1, 3'd2, 1'b1, "R7 storage empty");
    chk("R7 zero after clear", q_o, '0);

    // write immediately followed by demux, then hold
    step(1'b1, 1'b0, 3'd4, 1'b1, "R2 write before demux");
    step(1'b0, 1'b0, 3'd1, 1'b1, "R5 demux after write");
    step(1'b1, 1'b1, 3'd1, 1'b0, "R6 write survives demux");
    chk("R6 bit4 kept", q_o, onehot(3'd4));

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      if (m == 2'd3 && $urandom_range(0, 3) != 0) m = 2'd1;
      step(m[1], m[0] ^ m[1] ? 1'b0 : 1'b1, AW'($urandom()), 1'($urandom()),
           "R2 R4 R5 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule